// File: doc/BRIEF.md
# Tiled Synchronous RAM Composer

This block is a single-clock synchronous RAM whose word width and address width are parameters. Storage is built from fixed tiles of 4096 bits each. A tile can be shaped as 2048 words of 2 bits, 1024 of 4, 512 of 8 or 256 of 16. The block splits the word into columns. Each full 16-bit slice is one column, and any leftover low-order remainder forms a narrower final column. For each column the block picks the narrowest tile shape that holds it. It then stacks tiles of that shape by address until the requested depth is covered.

A column narrower than 16 bits takes a narrower and deeper tile shape. So a 512x24 memory needs two stacked 256x16 tiles plus a single 512x8 tile, which is three tiles instead of four. Upper address bits decode into per-tile write enables. A registered copy of those bits steers the read multiplexer, so the multiplexer stays aligned with the one-cycle read latency. The localparam `TILE_COUNT` reports how many tiles a configuration uses.

Top module: `tiled_ram`

## Requirements
- R1: A 256x8 configuration (`ADDR_W`=8, `DATA_W`=8) reports `TILE_COUNT` = 1, since one 512x8 tile covers it.
- R2: A width that is not a legal tile width is rounded up to the next legal one. A 512x10 configuration uses 16-bit tiles, reports `TILE_COUNT` = 2, and stores and returns all 10 bits of every word.
- R3: Words wider than 16 bits are split over tiles placed side by side that share one address. A 128x24 configuration reports `TILE_COUNT` = 2 and returns full 24-bit words.
- R4: Column shapes are mixed to save tiles. A 512x24 configuration reports `TILE_COUNT` = 3.
- R5: On a rising edge with `wr_en` high, `wr_data` is stored at `addr`. With `wr_en` low, no location changes.
- R6: `rd_data` shows, one cycle after each rising edge, the word held at the `addr` sampled on that edge. This holds whether or not a write happens.
- R7: A read of the address being written on the same edge returns the contents from before that write.
- R8: Stacked tiles are chosen by the upper address bits. A write to one address never disturbs another address, including across tile boundaries such as 255 and 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all reads and writes |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address shared by the read and the write |
| wr_data | input | DATA_W | Word to be stored |
| rd_data | output | DATA_W | Registered read word |

## Verification
A write and a read of the same address can fall on the same clock edge. In that case the read must return the old word, and the new word must appear only on the following read. The bench provokes this by writing an address on two consecutive edges and then reading it twice. Its per-clock reference model computes each expected read before it applies the write of that edge, so the returned word is judged against the old contents. The same overlap is checked by properties that compare `rd_data` against write data from two cycles earlier.

// File: rtl/tiled_ram_pkg.sv
package tiled_ram_pkg;
    localparam int TILE_BITS = 4096;
    localparam int MAX_TILE_W = 16;

    // Narrowest legal tile width holding a column of width w.
    function automatic int tile_width(input int w);
        if (w <= 2)      return 2;
        else if (w <= 4) return 4;
        else if (w <= 8) return 8;
        else             return MAX_TILE_W;
    endfunction

    // Address bits of one tile at a given width.
    function automatic int tile_abits(input int tw);
        return $clog2(TILE_BITS / tw);
    endfunction

    function automatic int col_count(input int w);
        return (w + MAX_TILE_W - 1) / MAX_TILE_W;
    endfunction

    // Width of column c: full slices first, remainder last.
    function automatic int col_width(input int w, input int c);
        if (c < w / MAX_TILE_W) return MAX_TILE_W;
        else                    return w % MAX_TILE_W;
    endfunction

    function automatic int stack_count(input int cw, input int aw);
        int taw;
        taw = tile_abits(tile_width(cw));
        if (aw > taw) return 1 << (aw - taw);
        else          return 1;
    endfunction

    function automatic int total_tiles(input int w, input int aw);
        int sum;
        sum = 0;
        for (int c = 0; c < col_count(w); c++)
            sum += stack_count(col_width(w, c), aw);
        return sum;
    endfunction
endpackage

// File: rtl/ram_tile.sv
module ram_tile #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WORDS = 1 << AW;

    // Only the connected bits of each location are modelled.
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[a] <= wd;
        rd <= cells[a];
    end
endmodule

// File: rtl/ram_column.sv
module ram_column
    import tiled_ram_pkg::*;
#(
    parameter int COL_W  = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [COL_W-1:0]  wr_data,
    output logic [COL_W-1:0]  rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TW    = tile_width(COL_W);
    localparam int TAW   = tile_abits(TW);
    localparam int NS    = stack_count(COL_W, ADDR_W);
    localparam int SEL_W = (NS > 1) ? $clog2(NS) : 1;
    localparam int LOW_W = (ADDR_W < TAW) ? ADDR_W : TAW;

    logic [TAW-1:0]   tile_addr;
    logic [COL_W-1:0] tile_rd [NS];

    assign tile_addr = TAW'(addr[LOW_W-1:0]);

    generate
        if (NS > 1) begin : g_stacked
            logic [SEL_W-1:0] sel;
            logic [SEL_W-1:0] sel_q;

            assign sel = addr[ADDR_W-1 -: SEL_W];

            always_ff @(posedge clk) sel_q <= sel;

            for (genvar s = 0; s < NS; s++) begin : g_tile
                ram_tile #(.DW(COL_W), .AW(TAW)) u_tile (
                    .clk (clk),
                    .we  (wr_en && (sel == SEL_W'(s))),
                    .a   (tile_addr),
                    .wd  (wr_data),
                    .rd  (tile_rd[s])
                );
            end

            assign rd_data = tile_rd[sel_q];
        end else begin : g_single
            ram_tile #(.DW(COL_W), .AW(TAW)) u_tile (
                .clk (clk),
                .we  (wr_en),
                .a   (tile_addr),
                .wd  (wr_data),
                .rd  (tile_rd[0])
            );

            assign rd_data = tile_rd[0];
        end
    endgenerate
endmodule

// File: rtl/tiled_ram.sv
module tiled_ram
    import tiled_ram_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCOL       = col_count(DATA_W);
    localparam int TILE_COUNT = total_tiles(DATA_W, ADDR_W);

    generate
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            localparam int CW  = col_width(DATA_W, c);
            localparam int LSB = c * MAX_TILE_W;

            ram_column #(.COL_W(CW), .ADDR_W(ADDR_W)) u_col (
                .clk     (clk),
                .wr_en   (wr_en),
                .addr    (addr),
                .wr_data (wr_data[LSB +: CW]),
                .rd_data (rd_data[LSB +: CW])
            );
        end
    endgenerate
endmodule

// File: rtl/tiled_ram_chk.sv
module tiled_ram_chk #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    // Edges seen so far, saturating; properties wait for three of history.
    logic [1:0] age = 2'd0;
    always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;

    assert_store_R5: assert property (@(posedge clk) disable iff (age != 2'd3)
        ($past(wr_en, 2) && !$past(wr_en) && $past(addr) == $past(addr, 2))
        |-> rd_data == $past(wr_data, 2));

    assert_old_on_write_R7: assert property (@(posedge clk) disable iff (age != 2'd3)
        ($past(wr_en, 2) && $past(wr_en) && $past(addr) == $past(addr, 2))
        |-> rd_data == $past(wr_data, 2));

    assert_read_hold_R6: assert property (@(posedge clk) disable iff (age != 2'd3)
        (!$past(wr_en, 2) && $past(addr) == $past(addr, 2))
        |-> rd_data == $past(rd_data));

    assert_isolate_R8: assert property (@(posedge clk) disable iff (age != 2'd3)
        ($past(wr_en, 3) && !$past(wr_en, 2) && !$past(wr_en)
         && $past(addr, 2) != $past(addr) && $past(addr, 3) == $past(addr))
        |-> rd_data == $past(wr_data, 3));
endmodule

bind tiled_ram tiled_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/tiled_ram_tb.sv
module tiled_ram_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        wr_en = 1'b1;
    logic [8:0]  addr = 9'd0;
    logic [23:0] wr_data = 24'd1;
    logic [7:0]  rd_w8;
    logic [9:0]  rd_w10;
    logic [23:0] rd_w24s;
    logic [23:0] rd_main;

    int checks = 0;
    int fails = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    string cur_req = "R5";

    always #10 clk = ~clk;

    tiled_ram #(.DATA_W(24), .ADDR_W(9)) dut_i (
        .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_main));
    tiled_ram #(.DATA_W(8), .ADDR_W(8)) dut_w8 (
        .clk(clk), .wr_en(wr_en), .addr(addr[7:0]), .wr_data(wr_data[7:0]), .rd_data(rd_w8));
    tiled_ram #(.DATA_W(10), .ADDR_W(9)) dut_w10 (
        .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data[9:0]), .rd_data(rd_w10));
    tiled_ram #(.DATA_W(24), .ADDR_W(7)) dut_w24s (
        .clk(clk), .wr_en(wr_en), .addr(addr[6:0]), .wr_data(wr_data), .rd_data(rd_w24s));

    // Reference model: one word array per configuration.
    int unsigned ref_mem [4][512];
    bit          ref_ok  [4][512];
    int unsigned exp_rd  [4];
    bit          exp_ok  [4];

    function automatic int unsigned amask(input int k);
        case (k)
            0: return 32'h1FF;
            1: return 32'hFF;
            2: return 32'h1FF;
            default: return 32'h7F;
        endcase
    endfunction

    function automatic int unsigned dmask(input int k);
        case (k)
            1: return 32'hFF;
            2: return 32'h3FF;
            default: return 32'hFFFFFF;
        endcase
    endfunction

    function automatic int unsigned got(input int k);
        case (k)
            0: return 32'(rd_main);
            1: return 32'(rd_w8);
            2: return 32'(rd_w10);
            default: return 32'(rd_w24s);
        endcase
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            int unsigned a;
            a = 32'(addr) & amask(k);
            exp_ok[k] = ref_ok[k][a];
            exp_rd[k] = ref_mem[k][a];
            if (wr_en) begin
                ref_mem[k][a] = 32'(wr_data) & dmask(k);
                ref_ok[k][a]  = 1'b1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every configuration on every clock, half a period after the edge.
    always @(negedge clk) begin
        if (running) begin
            for (int k = 0; k < 4; k++) begin
                if (exp_ok[k]) check(cur_req, $sformatf("read of config %0d", k), got(k), exp_rd[k]);
            end
        end
    end

    task automatic drive(input bit w, input int a, input int unsigned d);
        @(posedge clk);
        #2;
        wr_en   = w;
        addr    = 9'(a);
        wr_data = 24'(d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // Tile counts per configuration.
        check("R1", "tiles 256x8",  dut_w8.TILE_COUNT,   1);
        check("R2", "tiles 512x10", dut_w10.TILE_COUNT,  2);
        check("R3", "tiles 128x24", dut_w24s.TILE_COUNT, 2);
        check("R4", "tiles 512x24", dut_i.TILE_COUNT,    3);
        running = 1'b1;

        // R5: fill every address with 3*i+1.
        cur_req = "R5";
        wr_en = 1'b1; addr = 9'd0; wr_data = 24'd1;
        for (int i = 1; i < 512; i++) drive(1'b1, i, 3 * i + 1);

        // R6: read every address back, also through the stacked-tile boundary.
        cur_req = "R6";
        for (int i = 0; i < 512; i++) drive(1'b0, i, 0);

        // R7: write on two edges in a row, then read twice.
        cur_req = "R7";
        for (int i = 0; i < 32; i++) begin
            int a;
            a = i * 16 + 3;
            drive(1'b1, a, a * 7 + 5);
            drive(1'b1, a, a * 11 + 9 + 32'h5A0000);
            drive(1'b0, a, 0);
            drive(1'b0, a, 0);
        end

        // R8: tile-boundary and scattered mixed traffic.
        cur_req = "R8";
        drive(1'b1, 255, 32'hABCDEF);
        drive(1'b1, 256, 32'h123456);
        drive(1'b0, 255, 0);
        drive(1'b0, 256, 0);
        drive(1'b1, 511, 32'h0F0F0F);
        drive(1'b0, 0, 0);
        drive(1'b0, 511, 0);
        for (int i = 0; i < 600; i++) drive((i % 3) == 0, (i * 37) % 512, i * 5 + 7);
        for (int i = 0; i < 512; i++) drive(1'b0, i, 0);
        drive(1'b0, 0, 0);
        drive(1'b0, 0, 0);
        @(posedge clk);
        #2;
        running = 1'b0;
        finish_run();
    end
endmodule